// File: doc/BRIEF.md
# Digital PLL Microtick Generator

This block divides each period of a reference signal into a programmed number of evenly spaced one-clock pulses, called microticks. A signed delta accumulator does the division with error-accumulation arithmetic. While the accumulator is zero or positive, a negative step is added to it on every clock. Once it has gone negative, a reload value is added to it instead. Each clock in which the accumulator is negative is a microtick slot. Over P clocks this gives exactly N slots, and their spacings differ by at most one clock.

Software measures the reference period P, picks the pulse count N and programs three values: the step as the two's complement of N, the reload as P minus N, and the pulse count itself. The reference input is synchronized to the clock, and each rising edge reloads a countdown of the pulses still owed in the current period. In automatic mode the block stops emitting once the countdown reaches zero and waits for the next edge. With automatic mode off, a microtick is emitted in every slot and the countdown rests at zero. The block reports the remaining count and a busy flag.

Top module: `dpll_tick_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `tick_o` is 0, `remain_o` is 0 and `busy_o` is 0.
- R2: The first clock edge after reset loads the accumulator with `reload_i`. With reload 10, step 0xFFFD and automatic mode off, the first microtick is visible after the fifth clock edge following reset release.
- R3: Each later edge adds `step_i` when the accumulator is zero or positive, and adds `reload_i` when it is negative. With reload 10 and step 0xFFFD, successive microticks are 4, 5 and 4 clocks apart.
- R4: A 0-to-1 transition on `ref_i` goes through a two-flop synchronizer and a registered edge detector. Setting `ref_i` before edge k makes `remain_o` equal `pulses_i` after edge k+3, and `remain_o` is unchanged after edge k+2.
- R5: `tick_o` is high in exactly those cycles where the accumulator is negative and either `remain_o` is nonzero or automatic mode is off. Every such cycle with a nonzero count and no load pending decrements `remain_o` by one. A pending load takes priority over the decrement.
- R6: With `auto_en_i` = 1, no microtick is emitted while `remain_o` is 0. After one reference edge, exactly `pulses_i` microticks appear. `busy_o` is 1 exactly when `remain_o` is nonzero.
- R7: With `auto_en_i` = 0, microticks continue in every negative slot (6 in any 26 clocks for reload 10, step 0xFFFD), and `remain_o` stays at 0 instead of wrapping.
- R8: In steady state with a reference period P ≥ 2N, every window of P clocks contains N microticks, and their spacings differ by at most one clock.
- R9: Holding `ref_i` high, or taking it low, does not reload the countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_i | input | 1 | Reference signal, asynchronous to clk |
| auto_en_i | input | 1 | 1: stop emitting when the count reaches zero |
| pulses_i | input | CW (8) | Number of microticks per reference period |
| step_i | input | DW (16) | Signed step, the two's complement of the pulse count |
| reload_i | input | DW (16) | Signed reload, the period in clocks minus the pulse count |
| tick_o | output | 1 | One-clock microtick pulse |
| remain_o | output | CW (8) | Microticks still to be emitted in this period |
| busy_o | output | 1 | High while the remaining count is nonzero |

## Verification
The hardest situation to reach from the ports is a steady state in which the reference edge lands in the same cycle as a negative accumulator slot. There the load overrides the decrement, and the slot's tick is judged on the old count. The bench reaches this by sweeping several period and pulse-count pairs through whole reference periods, including P = 2N and N = 1, so that the edge phase falls on many different slots. A cycle-level model built from the requirements is compared with the design every clock. A directed run holds the reference high long enough to exhaust the count in automatic mode, then releases automatic mode to show saturation.

// File: rtl/dpll_pkg.sv
// Shared definitions for the digital PLL microtick generator.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package dpll_pkg;

    // Default widths of the arithmetic and count paths
    localparam int unsigned DPLL_DW = 16;
    localparam int unsigned DPLL_CW = 8;
    localparam int unsigned DPLL_SYNC = 2;

    // Phase of the delta accumulator: waiting for its first load, or running
    typedef enum logic {
        PH_PRIME = 1'b0,
        PH_RUN   = 1'b1
    } acc_phase_e;

endpackage

// File: rtl/dpll_ref_edge.sv
// Reference input conditioning.
// Brings an asynchronous reference into the clock domain through a chain of
// STAGES flops, then registers a rising-edge detect. The result is a pulse
// one clock wide.
// Assumes: STAGES >= 2; the reference stays high or low for at least two clocks.
module dpll_ref_edge #(
    parameter int unsigned STAGES = dpll_pkg::DPLL_SYNC
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_i,
    output logic rise_o
);

    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              rise_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                // First stage samples the raw reference
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= ref_i;
                end
            end else begin : g_next
                // Later stages shift the sample along the chain
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    // Registered edge detect on the synchronized level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            rise_q <= 1'b0;
        end else begin
            prev_q <= sync_q[LAST];
            rise_q <= sync_q[LAST] & ~prev_q;
        end
    end

    assign rise_o = rise_q;

endmodule

// File: rtl/dpll_delta_acc.sv
// Signed delta accumulator.
// On the first edge after reset it takes the reload value. From then on it
// adds the step while it is zero or positive and adds the reload while it is
// negative. Its sign bit marks the microtick slots.
// Assumes: step is negative, and the reload is positive and fits DW bits.
module dpll_delta_acc #(
    parameter int unsigned DW = dpll_pkg::DPLL_DW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW-1:0] step_i,
    input  logic signed [DW-1:0] reload_i,
    output logic                 neg_o
);
    import dpll_pkg::*;

    localparam int unsigned SIGN = DW - 1;

    acc_phase_e          phase_q;
    logic signed [DW-1:0] acc_q;
    logic signed [DW-1:0] addend;

    // Choose the addend from the sign of the current value
    always_comb begin
        if (acc_q[SIGN]) addend = reload_i;
        else             addend = step_i;
    end

    // Load once after reset, then accumulate on every clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_PRIME;
            acc_q   <= '0;
        end else if (phase_q == PH_PRIME) begin
            phase_q <= PH_RUN;
            acc_q   <= reload_i;
        end else begin
            acc_q   <= acc_q + addend;
        end
    end

    assign neg_o = acc_q[SIGN];

endmodule

// File: rtl/dpll_tick_count.sv
// Microtick countdown and output gating.
// A load pulse sets the count to the programmed pulse number. A negative slot
// with a nonzero count decrements it, and the count never wraps below zero.
// A slot becomes a microtick when the count is nonzero or automatic mode is off.
// Assumes: load is a one-clock pulse; a load in a slot cycle wins over the decrement.
module dpll_tick_count #(
    parameter int unsigned CW = dpll_pkg::DPLL_CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          slot_i,
    input  logic          auto_i,
    input  logic [CW-1:0] pulses_i,
    output logic [CW-1:0] count_o,
    output logic          tick_o,
    output logic          busy_o
);

    logic [CW-1:0] cnt_q;
    logic          nonzero;

    // Detect a count that still owes microticks
    always_comb nonzero = |cnt_q;

    // Load on a reference edge, otherwise count down one per used slot
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (load_i)             cnt_q <= pulses_i;
        else if (slot_i && nonzero)  cnt_q <= cnt_q - 1'b1;
    end

    // Gate the slot into a microtick
    always_comb tick_o = slot_i & (nonzero | ~auto_i);

    assign count_o = cnt_q;
    assign busy_o  = nonzero;

endmodule

// File: rtl/dpll_tick_gen.sv
// Digital PLL microtick generator, top level.
// Connects reference conditioning, the delta accumulator and the countdown.
// Assumes: software programs step = -pulses and reload = period - pulses.
module dpll_tick_gen #(
    parameter int unsigned DW    = dpll_pkg::DPLL_DW,
    parameter int unsigned CW    = dpll_pkg::DPLL_CW,
    parameter int unsigned SYNC  = dpll_pkg::DPLL_SYNC
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ref_i,
    input  logic                 auto_en_i,
    input  logic [CW-1:0]        pulses_i,
    input  logic signed [DW-1:0] step_i,
    input  logic signed [DW-1:0] reload_i,
    output logic                 tick_o,
    output logic [CW-1:0]        remain_o,
    output logic                 busy_o
);

    logic load_pulse;
    logic slot;

    dpll_ref_edge #(.STAGES(SYNC)) i_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_i  (ref_i),
        .rise_o (load_pulse)
    );

    dpll_delta_acc #(.DW(DW)) i_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_i   (step_i),
        .reload_i (reload_i),
        .neg_o    (slot)
    );

    dpll_tick_count #(.CW(CW)) i_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_pulse),
        .slot_i   (slot),
        .auto_i   (auto_en_i),
        .pulses_i (pulses_i),
        .count_o  (remain_o),
        .tick_o   (tick_o),
        .busy_o   (busy_o)
    );

endmodule

// File: rtl/dpll_tick_gen_chk.sv
// Property checker for the microtick generator, bound to the top level.
// Assumes: the internal load pulse of the top is named load_pulse.
module dpll_tick_gen_chk #(
    parameter int unsigned CW = dpll_pkg::DPLL_CW
) (
    input logic          clk,
    input logic          rst_n,
    input logic          auto_en_i,
    input logic [CW-1:0] pulses_i,
    input logic          load,
    input logic          tick_o,
    input logic [CW-1:0] remain_o
);

    // R4
    r4_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> remain_o == $past(pulses_i));

    // R4
    r4_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !load);

    // R5
    r5_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && tick_o && remain_o != '0) |=> remain_o == $past(remain_o) - 1'b1);

    // R6
    r6_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en_i && remain_o == '0) |-> !tick_o);

    // R7
    r7_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> remain_o <= $past(remain_o));

endmodule

bind dpll_tick_gen dpll_tick_gen_chk #(.CW(CW)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .auto_en_i (auto_en_i),
    .pulses_i  (pulses_i),
    .load      (load_pulse),
    .tick_o    (tick_o),
    .remain_o  (remain_o)
);

// File: tb/test_dpll_tick_gen.sv
module test_dpll_tick_gen;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;
    // Each entry: period P, pulse count N, automatic mode
    localparam int VEC [NV][3] = '{
        '{13, 3, 1}, '{13, 3, 0}, '{20, 4, 1}, '{17, 5, 1},
        '{9, 2, 0},  '{30, 7, 1}, '{8, 4, 1},  '{16, 1, 0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_i = 1'b0;
    logic auto_en_i = 1'b0;
    logic [7:0] pulses_i = 8'd0;
    logic signed [15:0] step_i = '0;
    logic signed [15:0] reload_i = '0;
    logic tick_o;
    logic [7:0] remain_o;
    logic busy_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dpll_tick_gen i_dpll_tick_gen (
        .clk(clk), .rst_n(rst_n), .ref_i(ref_i), .auto_en_i(auto_en_i),
        .pulses_i(pulses_i), .step_i(step_i), .reload_i(reload_i),
        .tick_o(tick_o), .remain_o(remain_o), .busy_o(busy_o)
    );

    // Cycle-level reference model built from the requirements
    logic m_s1, m_s2, m_pv, m_rise, m_primed;
    logic signed [15:0] m_acc;
    logic [7:0] m_cnt;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= 0; m_s2 <= 0; m_pv <= 0; m_rise <= 0; m_primed <= 0;
            m_acc <= 0; m_cnt <= 0;
        end else begin
            m_s1 <= ref_i; m_s2 <= m_s1; m_pv <= m_s2; m_rise <= m_s2 & ~m_pv;
            if (!m_primed) begin m_acc <= reload_i; m_primed <= 1; end
            else if (m_acc < 0) m_acc <= m_acc + reload_i;
            else m_acc <= m_acc + step_i;
            if (m_rise) m_cnt <= pulses_i;
            else if (m_acc < 0 && m_cnt != 0) m_cnt <= m_cnt - 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Advance one clock, sample at the falling edge and compare with the model
    task automatic step();
        logic exp_tick;
        @(negedge clk);
        exp_tick = (m_acc < 0) && (m_cnt != 0 || !auto_en_i);
        chk(tick_o == exp_tick, "R5 tick", int'(tick_o), int'(exp_tick));
        chk(remain_o == m_cnt, "R5 remain", int'(remain_o), int'(m_cnt));
        chk(busy_o == (m_cnt != 0), "R6 busy", int'(busy_o), int'(m_cnt != 0));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        ref_i = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        total++; bad++;
        $display("FAIL watchdog actual=1 expected=0");
        finish_run();
    end

    initial begin
        int first, last, idx, win, smin, smax;
        int times [4];

        // R1: reset state
        auto_en_i = 0; pulses_i = 3; step_i = -16'sd3; reload_i = 16'sd10;
        rst_n = 0;
        repeat (2) @(negedge clk);
        chk(tick_o == 0, "R1 tick", int'(tick_o), 0);
        chk(remain_o == 0, "R1 remain", int'(remain_o), 0);
        chk(busy_o == 0, "R1 busy", int'(busy_o), 0);
        rst_n = 1;
        step();
        chk(tick_o == 0 && remain_o == 0 && busy_o == 0, "R1 first cycle", int'(remain_o), 0);

        // R2, R3: first tick after 5 edges, then spacings 4,5,4; R7 saturation
        do_reset();
        idx = 0;
        for (int c = 1; c <= 20; c++) begin
            step();
            if (tick_o && idx < 4) begin times[idx] = c; idx++; end
            chk(remain_o == 0, "R7 saturate", int'(remain_o), 0);
        end
        chk(times[0] == 5, "R2 first tick", times[0], 5);
        chk(times[1] - times[0] == 4, "R3 gap1", times[1] - times[0], 4);
        chk(times[2] - times[1] == 5, "R3 gap2", times[2] - times[1], 5);
        chk(times[3] - times[2] == 4, "R3 gap3", times[3] - times[2], 4);

        // R4: load latency; R6: exactly N ticks then stop; R9: no reload on level
        auto_en_i = 1;
        step();
        ref_i = 1;
        win = 0;
        step(); win += tick_o; step(); win += tick_o; step(); win += tick_o;
        chk(remain_o == 0, "R4 before load", int'(remain_o), 0);
        step();
        chk(remain_o == 3, "R4 loaded", int'(remain_o), 3);
        chk(busy_o == 1, "R6 busy on load", int'(busy_o), 1);
        win += tick_o;
        for (int c = 0; c < 40; c++) begin step(); win += tick_o; end
        chk(win == 3, "R6 tick total", win, 3);
        chk(remain_o == 0 && busy_o == 0, "R6 idle", int'(remain_o), 0);
        ref_i = 0;
        win = 0;
        for (int c = 0; c < 15; c++) begin step(); win += tick_o; end
        chk(win == 0, "R9 no ticks after fall", win, 0);
        chk(remain_o == 0, "R9 no reload", int'(remain_o), 0);

        // R7: automatic mode off resumes every slot
        auto_en_i = 0;
        step();
        win = 0;
        for (int c = 0; c < 26; c++) begin
            step(); win += tick_o;
            chk(remain_o == 0, "R7 no wrap", int'(remain_o), 0);
        end
        chk(win == 6, "R7 tick count", win, 6);

        // R8: steady state over the vector table
        for (int v = 0; v < NV; v++) begin
            int p, n;
            p = VEC[v][0]; n = VEC[v][1];
            auto_en_i = VEC[v][2][0];
            pulses_i = 8'(n);
            step_i = 16'(-n);
            reload_i = 16'(p - n);
            do_reset();
            win = 0; last = -1; smin = 1000; smax = 0; first = 0;
            for (int c = 0; c < 7 * p; c++) begin
                step();
                if (tick_o) begin
                    if (c >= 4 * p && c < 5 * p) win++;
                    if (c >= 2 * p && c < 6 * p) begin
                        if (last >= 0) begin
                            if (c - last < smin) smin = c - last;
                            if (c - last > smax) smax = c - last;
                        end
                        last = c;
                        first++;
                    end
                end
                ref_i = (c < 6 * p) && ((c % p) < p / 2);
            end
            chk(win == n, "R8 ticks per period", win, n);
            chk(first > 1 && smax - smin <= 1, "R8 spacing spread", smax - smin, 1);
        end

        finish_run();
    end

endmodule